// File: doc/BRIEF.md
# Configurable-Latency 32x32 Multiply Unit

This execution unit forms the product of two 32-bit operands and returns one 32-bit word of it. The 5-bit opcode picks which word: the low half of the product, the high half with both operands read as unsigned, or the high half with both operands read as two's complement. Every request is self-contained. A high-word request computes the full product from its own operands and does not rely on any earlier low-word request.

The build parameter `EXTRA_CLOCKS` sets the unit's latency relative to a single-cycle ALU operation. A value of 1 or 2 adds that many clocks; larger values stretch the product pipeline further. A value of 0 leaves the multiplier out. A multiply request then raises an illegal-instruction pulse and produces no result. While a request is in flight the unit reports busy and ignores further starts. With each result it reports whether the condition flags are to be written, together with zero and negative indications taken from the result word.

Top module: `mpy_unit`

## Requirements
- R1: Opcode 5'h08 returns bits 31:0 of the 64-bit product. This word is the same whether the operands are read as signed or as unsigned.
- R2: Opcode 5'h0a returns bits 63:32 of the product with both operands read as unsigned.
- R3: Opcode 5'h0b returns bits 63:32 of the product with both operands read as two's complement.
- R4: Suppose a request is accepted at clock edge k and `EXTRA_CLOCKS` = S (S >= 1). Then `valid_o` is high for exactly one cycle, the one following edge k+S, and `result_o` holds that request's word during that cycle.
- R5: `busy_o` is high in the S cycles that follow edge k through edge k+S-1, and low while `valid_o` is high. A start is accepted only when `busy_o` is low, and a start during a busy cycle has no effect. A start in the cycle where `valid_o` is high is accepted.
- R6: A start carrying any opcode other than 5'h08, 5'h0a or 5'h0b is ignored: no busy, no valid and no illegal pulse follow.
- R7: With `EXTRA_CLOCKS` = 0, a start with one of the three multiply opcodes makes `illegal_o` high for the single cycle after that edge, and `valid_o` and `busy_o` stay low. With `EXTRA_CLOCKS` >= 1, `illegal_o` stays low.
- R8: `flag_we_o` is high together with `valid_o` for opcodes 5'h08 and 5'h0b, and low for 5'h0a.
- R9: While `valid_o` is high, `zero_o` is 1 exactly when `result_o` is zero, and `neg_o` equals `result_o[31]`.
- R10: A synchronous active-high `rst` clears `valid_o`, `busy_o` and `illegal_o` at the next edge and discards any request in flight, so its result never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request strobe |
| op_i | input | 5 | Opcode of the request |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Selected product word, meaningful while valid_o is high |
| valid_o | output | 1 | One-cycle result strobe |
| busy_o | output | 1 | Request in flight, new starts ignored |
| illegal_o | output | 1 | Illegal-instruction pulse when the multiplier is not built |
| flag_we_o | output | 1 | Condition flags to be written from this result |
| zero_o | output | 1 | Result word is zero |
| neg_o | output | 1 | Bit 31 of the result word |

## Verification
Result delivery and acceptance of the next request can occur in the same cycle. A start that arrives while `valid_o` is high must be taken, and the word being delivered must remain that of the earlier request. The bench drives starts in most cycles with random opcodes and operands. This produces many such overlaps for both the one-clock and the two-clock builds. At every cycle a model in the bench decides from the requirements whether a start is accepted, and which word each valid strobe must carry. A reset dropped into a busy stretch also lands in the same cycle as an in-flight request, and the bench checks that the discarded result never shows up.

// File: rtl/mpy_pkg.sv
package mpy_pkg;

    localparam int WORD_W = 32;
    localparam int OP_W   = 5;

    localparam logic [OP_W-1:0] OPC_LO   = 5'h08;
    localparam logic [OP_W-1:0] OPC_HI_U = 5'h0a;
    localparam logic [OP_W-1:0] OPC_HI_S = 5'h0b;

    typedef logic [WORD_W-1:0]          word_t;
    typedef logic signed [WORD_W:0]     ext_t;
    typedef logic signed [2*WORD_W-1:0] wide_t;

    // request as captured at acceptance
    typedef struct packed {
        logic hi_sel;
        logic flag_en;
        ext_t a_ext;
        ext_t b_ext;
    } mul_req_t;

    // product travelling down the delay stages
    typedef struct packed {
        logic  hi_sel;
        logic  flag_en;
        wide_t prod;
    } mul_prod_t;

    typedef struct packed {
        logic zero;
        logic neg;
    } res_flags_t;

    function automatic logic is_mul_op(logic [OP_W-1:0] op);
        return (op == OPC_LO) || (op == OPC_HI_U) || (op == OPC_HI_S);
    endfunction

    function automatic ext_t extend(word_t v, logic sgn);
        return {sgn & v[WORD_W-1], v};
    endfunction

    function automatic mul_req_t build_req(logic [OP_W-1:0] op, word_t a, word_t b);
        mul_req_t r;
        logic     sgn;
        sgn       = (op == OPC_HI_S);
        r.hi_sel  = (op != OPC_LO);
        r.flag_en = (op != OPC_HI_U);
        r.a_ext   = extend(a, sgn);
        r.b_ext   = extend(b, sgn);
        return r;
    endfunction

endpackage

// File: rtl/mpy_decode.sv
module mpy_decode
    import mpy_pkg::*;
#(
    parameter bit ENABLED = 1'b1
) (
    input  logic            start_i,
    input  logic [OP_W-1:0] op_i,
    input  word_t           a_i,
    input  word_t           b_i,
    input  logic            busy_i,
    output logic            accept_o,
    output logic            trap_o,
    output mul_req_t        req_o
);

    logic mul_hit;

    always_comb begin
        mul_hit  = start_i && is_mul_op(op_i);
        accept_o = ENABLED && mul_hit && !busy_i;
        trap_o   = !ENABLED && mul_hit;
        req_o    = build_req(op_i, a_i, b_i);
    end

endmodule

// File: rtl/mpy_flags.sv
module mpy_flags
    import mpy_pkg::*;
(
    input  word_t      word_i,
    output res_flags_t flags_o
);

    always_comb begin
        flags_o.zero = (word_i == '0);
        flags_o.neg  = word_i[WORD_W-1];
    end

endmodule

// File: rtl/mpy_pipe.sv
module mpy_pipe
    import mpy_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     accept_i,
    input  mul_req_t req_i,
    output word_t    result_o,
    output logic     valid_o,
    output logic     busy_o,
    output logic     flag_we_o,
    output logic     zero_o,
    output logic     neg_o
);

    localparam int LAST = STAGES - 1;

    mul_req_t   req_q;
    logic [STAGES:0] vld;
    mul_prod_t  prod_c;
    mul_prod_t  prod_last;
    word_t      sel_word;
    res_flags_t flags_c;
    word_t      res_q;
    logic       fwe_q;
    res_flags_t flags_q;

    // operand capture
    always_ff @(posedge clk) begin
        if (accept_i) begin
            req_q <= req_i;
        end
    end

    // occupancy track, one bit per stage
    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            vld <= {vld[STAGES-1:0], accept_i};
        end
    end

    always_comb begin
        prod_c.hi_sel  = req_q.hi_sel;
        prod_c.flag_en = req_q.flag_en;
        prod_c.prod    = $signed(req_q.a_ext) * $signed(req_q.b_ext);
    end

    generate
        if (STAGES > 1) begin : g_dly
            mul_prod_t prod_q [1:LAST];
            always_ff @(posedge clk) begin
                prod_q[1] <= prod_c;
                for (int j = 2; j <= LAST; j++) begin
                    prod_q[j] <= prod_q[j-1];
                end
            end
            assign prod_last = prod_q[LAST];
        end else begin : g_nodly
            assign prod_last = prod_c;
        end
    endgenerate

    assign sel_word = prod_last.hi_sel ? prod_last.prod[2*WORD_W-1:WORD_W]
                                       : prod_last.prod[WORD_W-1:0];

    mpy_flags u_flags (
        .word_i  (sel_word),
        .flags_o (flags_c)
    );

    always_ff @(posedge clk) begin
        if (vld[LAST]) begin
            res_q   <= sel_word;
            fwe_q   <= prod_last.flag_en;
            flags_q <= flags_c;
        end
    end

    assign valid_o   = vld[STAGES];
    assign busy_o    = |vld[LAST:0];
    assign result_o  = res_q;
    assign flag_we_o = valid_o && fwe_q;
    assign zero_o    = flags_q.zero;
    assign neg_o     = flags_q.neg;

endmodule

// File: rtl/mpy_unit.sv
module mpy_unit
    import mpy_pkg::*;
#(
    parameter int EXTRA_CLOCKS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [4:0]  op_i,
    input  logic [31:0] a_i,
    input  logic [31:0] b_i,
    output logic [31:0] result_o,
    output logic        valid_o,
    output logic        busy_o,
    output logic        illegal_o,
    output logic        flag_we_o,
    output logic        zero_o,
    output logic        neg_o
);

    logic     accept;
    logic     trap;
    mul_req_t req;
    logic     illegal_q;

    mpy_decode #(
        .ENABLED (EXTRA_CLOCKS > 0)
    ) u_decode (
        .start_i  (start_i),
        .op_i     (op_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .busy_i   (busy_o),
        .accept_o (accept),
        .trap_o   (trap),
        .req_o    (req)
    );

    generate
        if (EXTRA_CLOCKS > 0) begin : g_on
            mpy_pipe #(
                .STAGES (EXTRA_CLOCKS)
            ) u_pipe (
                .clk       (clk),
                .rst       (rst),
                .accept_i  (accept),
                .req_i     (req),
                .result_o  (result_o),
                .valid_o   (valid_o),
                .busy_o    (busy_o),
                .flag_we_o (flag_we_o),
                .zero_o    (zero_o),
                .neg_o     (neg_o)
            );
        end else begin : g_off
            assign result_o  = '0;
            assign valid_o   = 1'b0;
            assign busy_o    = 1'b0;
            assign flag_we_o = 1'b0;
            assign zero_o    = 1'b0;
            assign neg_o     = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= trap;
        end
    end

    assign illegal_o = illegal_q;

endmodule

// File: rtl/mpy_unit_chk.sv
module mpy_unit_chk
    import mpy_pkg::*;
#(
    parameter int EXTRA_CLOCKS = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic [4:0]  op_i,
    input logic [31:0] result_o,
    input logic        valid_o,
    input logic        busy_o,
    input logic        illegal_o,
    input logic        flag_we_o,
    input logic        zero_o,
    input logic        neg_o
);

    // R5: delivery and occupancy never overlap
    a_r5_busy_valid_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && valid_o));

    // R4: a result strobe lasts one cycle
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R8: flag write only with a result
    a_r8_flag_we_valid: assert property (@(posedge clk) disable iff (rst)
        flag_we_o |-> valid_o);

    // R9: flags follow the delivered word
    a_r9_zero_flag: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (zero_o == (result_o == 32'd0)));

    a_r9_neg_flag: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (neg_o == result_o[31]));

    // R7: illegal pulse only after a start, never with a result or busy
    a_r7_illegal_cause: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> ($past(start_i) && !valid_o && !busy_o));

    // R10: reset clears the outputs at the next edge
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!valid_o && !busy_o && !illegal_o));

    // R6: a foreign opcode on an idle unit leaves it idle
    a_r6_foreign_ignored: assert property (@(posedge clk) disable iff (rst)
        (start_i && !is_mul_op(op_i) && !busy_o) |=> (!busy_o && !illegal_o));

    generate
        if (EXTRA_CLOCKS > 0) begin : g_acc
            // R5: an accepted request makes the unit busy
            a_r5_accept_busy: assert property (@(posedge clk) disable iff (rst)
                (start_i && is_mul_op(op_i) && !busy_o) |=> busy_o);
        end
    endgenerate

endmodule

bind mpy_unit mpy_unit_chk #(.EXTRA_CLOCKS(EXTRA_CLOCKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .op_i      (op_i),
    .result_o  (result_o),
    .valid_o   (valid_o),
    .busy_o    (busy_o),
    .illegal_o (illegal_o),
    .flag_we_o (flag_we_o),
    .zero_o    (zero_o),
    .neg_o     (neg_o)
);

// File: tb/test_mpy_unit.sv
`timescale 1ns/1ps
module test_mpy_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  op = 5'h00;
    logic [31:0] a = 32'd0;
    logic [31:0] b = 32'd0;

    logic [31:0] res0, res1, res2;
    logic v0, v1, v2, bz0, bz1, bz2, il0, il1, il2;
    logic fw0, fw1, fw2, z0, z1, z2, n0, n1, n2;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    mpy_unit #(.EXTRA_CLOCKS(2)) i_mpy_unit (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
        .result_o(res0), .valid_o(v0), .busy_o(bz0), .illegal_o(il0),
        .flag_we_o(fw0), .zero_o(z0), .neg_o(n0));

    mpy_unit #(.EXTRA_CLOCKS(1)) i_mpy_unit_one (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
        .result_o(res1), .valid_o(v1), .busy_o(bz1), .illegal_o(il1),
        .flag_we_o(fw1), .zero_o(z1), .neg_o(n1));

    mpy_unit #(.EXTRA_CLOCKS(0)) i_mpy_unit_off (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
        .result_o(res2), .valid_o(v2), .busy_o(bz2), .illegal_o(il2),
        .flag_we_o(fw2), .zero_o(z2), .neg_o(n2));

    function automatic bit mul_op(logic [4:0] o);
        return (o == 5'h08) || (o == 5'h0a) || (o == 5'h0b);
    endfunction

    function automatic logic [31:0] ref_word(logic [4:0] o, logic [31:0] x, logic [31:0] y);
        logic [63:0]        pu;
        logic signed [63:0] ps;
        pu = {32'd0, x} * {32'd0, y};
        ps = $signed({{32{x[31]}}, x}) * $signed({{32{y[31]}}, y});
        case (o)
            5'h08:   return pu[31:0];
            5'h0a:   return pu[63:32];
            default: return ps[63:32];
        endcase
    endfunction

    function automatic logic [31:0] signed_low(logic [31:0] x, logic [31:0] y);
        logic signed [63:0] ps;
        ps = $signed({{32{x[31]}}, x}) * $signed({{32{y[31]}}, y});
        return ps[31:0];
    endfunction

    function automatic logic [31:0] corner(int k);
        case (k % 6)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hffff_ffff;
            3: return 32'h8000_0000;
            4: return 32'h7fff_ffff;
            default: return 32'h0000_0002;
        endcase
    endfunction

    // reference model, index 0: two extra clocks, index 1: one
    int          cnt [2];
    logic        ev [2];
    logic [31:0] pa [2], pb [2], ea [2], eb [2];
    logic [4:0]  pop [2], eop [2];
    logic        eill = 1'b0;
    logic        prev_rst = 1'b1;
    logic        prev_foreign = 1'b0;

    initial begin
        for (int i = 0; i < 2; i++) begin
            cnt[i] = 0; ev[i] = 1'b0;
        end
    end

    always begin
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            int  s;
            bit  acc;
            s = (i == 0) ? 2 : 1;
            if (rst) begin
                cnt[i] = 0;
                ev[i]  = 1'b0;
            end else begin
                acc = start && mul_op(op) && (cnt[i] == 0);
                if (cnt[i] > 0) begin
                    cnt[i] = cnt[i] - 1;
                    ev[i]  = (cnt[i] == 0);
                    if (cnt[i] == 0) begin
                        eop[i] = pop[i]; ea[i] = pa[i]; eb[i] = pb[i];
                    end
                end else begin
                    ev[i] = 1'b0;
                end
                if (acc) begin
                    cnt[i] = s;
                    pop[i] = op; pa[i] = a; pb[i] = b;
                end
            end
        end
        eill         = !rst && start && mul_op(op);
        prev_rst     = rst;
        prev_foreign = !rst && start && !mul_op(op);
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_on(input int i, input logic [31:0] r, input logic v,
                            input logic bz, input logic il, input logic fw,
                            input logic z, input logic n);
        string lv, lb;
        lv = prev_rst ? "R10" : "R4";
        lb = prev_rst ? "R10" : (prev_foreign && cnt[i] == 0) ? "R6" : "R5";
        chk(lv, $sformatf("valid inst%0d", i), {31'd0, v}, {31'd0, ev[i]});
        chk(lb, $sformatf("busy inst%0d", i), {31'd0, bz}, {31'd0, cnt[i] > 0});
        chk("R7", $sformatf("illegal inst%0d", i), {31'd0, il}, 32'd0);
        if (ev[i] && v) begin
            logic [31:0] w;
            w = ref_word(eop[i], ea[i], eb[i]);
            case (eop[i])
                5'h08: begin
                    chk("R1", "low word", r, w);
                    chk("R1", "low word vs signed", r, signed_low(ea[i], eb[i]));
                end
                5'h0a:   chk("R2", "unsigned high", r, w);
                default: chk("R3", "signed high", r, w);
            endcase
            chk("R8", "flag write", {31'd0, fw}, {31'd0, eop[i] != 5'h0a});
            chk("R9", "zero flag", {31'd0, z}, {31'd0, w == 32'd0});
            chk("R9", "neg flag", {31'd0, n}, {31'd0, w[31]});
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            if (cyc >= 1) begin
                check_on(0, res0, v0, bz0, il0, fw0, z0, n0);
                check_on(1, res1, v1, bz1, il1, fw1, z1, n1);
                chk(prev_rst ? "R10" : "R7", "illegal off", {31'd0, il2}, {31'd0, eill});
                chk("R7", "valid off", {31'd0, v2}, 32'd0);
                chk("R7", "busy off", {31'd0, bz2}, 32'd0);
            end
            rst = (cyc < 3) || (cyc == 1500) || (cyc == 2601);
            if (cyc >= 3 && cyc < 60) begin
                start = 1'b1;
                case (cyc % 3)
                    0: op = 5'h08;
                    1: op = 5'h0a;
                    default: op = 5'h0b;
                endcase
                a = corner(cyc);
                b = corner(cyc / 6);
            end else begin
                int r;
                start = ($urandom % 5) != 0;
                r = $urandom % 20;
                if (r < 6)       op = 5'h08;
                else if (r < 12) op = 5'h0a;
                else if (r < 18) op = 5'h0b;
                else begin
                    op = 5'($urandom % 32);
                    if (mul_op(op)) op = 5'h00;
                end
                a = ($urandom % 4 == 0) ? corner($urandom % 6) : $urandom;
                b = ($urandom % 4 == 0) ? corner($urandom % 6) : $urandom;
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        for (int t = 0; t < 200000; t++) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule